// File: doc/BRIEF.md
# Two-Stage RISC-V Subset Processor Core

This block is a 32-bit processor core for a reduced RISC-V instruction subset: add, addi, sub, and, or, slli, mul, lw, sw, beq, bne, jal, jalr, and one extra halt instruction. The core has two pipeline stages. The first stage fetches an instruction word, decodes it, reads operands, runs the ALU and chooses the next program counter. The second stage does the data memory access and the register writeback.

The program counter counts instruction words, and the fetch port is indexed by that count. The core never stalls and never flushes. Branches and jumps resolve in the first stage. A result waiting in the second stage is forwarded to the operand reads of the instruction behind it, and this includes a word just loaded from data memory. So every instruction takes exactly one cycle.

Both memories sit outside the core. Instruction memory is read combinationally at `imem_addr`. Data memory has a combinational read and a write on the clock edge, and it is addressed in 32-bit words.

Top module: `rv2_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core sets `imem_addr` to 1, clears `halted` and the register file, and drops `dmem_we`. The first instruction executed after reset is the one at instruction location 1.
- R2: add, sub, and, or, addi and mul follow the standard RISC-V encodings. mul is R-type with funct7 = 0000001 and funct3 = 000, and it writes the low 32 bits of the product. sub results wrap modulo 2^32.
- R3: slli (opcode 0010011, funct3 001) shifts left by the low five bits of the 12-bit immediate and ignores the higher immediate bits.
- R4: When an instruction reads the register written by the instruction just before it, it receives the new value. This applies to ALU results, link values and loaded words, and to store data as well as source operands. No cycle is inserted.
- R5: lw and sw form the byte address rs1 + immediate. Data memory is accessed at word address = byte address >> 2, so unaligned addresses round down.
- R6: beq and bne compare two registers. When the branch is taken, the next location is the branch's own location plus the immediate divided by 4. This works for forward and backward offsets. When the branch is not taken, the next location is the current one plus 1.
- R7: jal jumps to its own location plus the immediate divided by 4. jalr jumps to (rs1 + immediate) >> 2. Both write 4 × (own location + 1) into rd.
- R8: Writes that name x0 are discarded, and x0 reads as zero, including when forwarding is active.
- R9: The instruction with opcode 1111111 halts the core. `halted` goes high at the next edge and stays high until reset. `imem_addr` then stays fixed, and no instruction after the halt writes a register or memory. Instructions before the halt complete.
- R10: Every instruction completes in one cycle. A program that executes N instructions, counting the halt, raises `halted` at the Nth clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction location being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | DA_W | Data memory word address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 32 | Data memory write word |
| dmem_rdata | input | 32 | Data memory read word at `dmem_addr` |
| halted | output | 1 | Core has executed a halt |

## Verification
The hardest situation to create is a value that is still in flight in the second stage while the next instruction consumes it. This covers a load feeding an addi, a load feeding a store's data operand, and a link value feeding a store. The only visible evidence of these cases is what later lands in data memory. The stimulus is therefore a single program that places every producer directly before its consumer. It mixes in taken, not-taken and backward branches, plus jumps over instructions that would otherwise leave marks in memory. The program ends in a halt followed by a store that must never land. The bench compares every data word against values worked out by hand, and it counts the edges up to `halted` to confirm one cycle per instruction.

// File: rtl/rv2_pkg.sv
package rv2_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_STOP   = 7'b1111111;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_MUL, ALU_SLL
    } alu_op_e;

    typedef enum logic [2:0] {
        FL_SEQ, FL_BEQ, FL_BNE, FL_JAL, FL_JALR, FL_STOP
    } flow_e;

    // decoded first-stage control
    typedef struct packed {
        alu_op_e            alu_op;
        flow_e              flow;
        logic               use_imm;
        logic               reg_wr;
        logic               mem_rd;
        logic               mem_wr;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs1;
        logic [RIDX_W-1:0]  rs2;
        logic [XLEN-1:0]    imm;
    } dec_t;

    // stage boundary register contents
    typedef struct packed {
        logic               reg_wr;
        logic               mem_rd;
        logic               mem_wr;
        logic [RIDX_W-1:0]  rd;
        logic [XLEN-1:0]    result;
        logic [XLEN-1:0]    sdata;
    } mw_t;

    function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
        return {{20{w[31]}}, w[31:20]};
    endfunction

    function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
        return {{20{w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic logic [XLEN-1:0] imm_b(input logic [31:0] w);
        return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] imm_j(input logic [31:0] w);
        return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction

endpackage

// File: rtl/rv2_decode.sv
module rv2_decode
    import rv2_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    always_comb begin
        dec         = '0;
        dec.alu_op  = ALU_ADD;
        dec.flow    = FL_SEQ;
        dec.rd      = instr[11:7];
        dec.rs1     = instr[19:15];
        dec.rs2     = instr[24:20];
        dec.imm     = imm_i(instr);
        unique case (opc)
            OPC_REG: begin
                dec.reg_wr = 1'b1;
                if (f7 == 7'b0000001 && f3 == 3'b000) dec.alu_op = ALU_MUL;
                else if (f3 == 3'b000)                dec.alu_op = f7[5] ? ALU_SUB : ALU_ADD;
                else if (f3 == 3'b111)                dec.alu_op = ALU_AND;
                else if (f3 == 3'b110)                dec.alu_op = ALU_OR;
                else                                  dec.reg_wr = 1'b0;
            end
            OPC_IMM: begin
                dec.use_imm = 1'b1;
                dec.reg_wr  = (f3 == 3'b000) || (f3 == 3'b001);
                dec.alu_op  = (f3 == 3'b001) ? ALU_SLL : ALU_ADD;
            end
            OPC_LOAD: begin
                dec.use_imm = 1'b1;
                dec.reg_wr  = 1'b1;
                dec.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                dec.use_imm = 1'b1;
                dec.mem_wr  = 1'b1;
                dec.imm     = imm_s(instr);
            end
            OPC_BRANCH: begin
                dec.imm  = imm_b(instr);
                dec.flow = (f3 == 3'b001) ? FL_BNE : FL_BEQ;
            end
            OPC_JAL: begin
                dec.imm    = imm_j(instr);
                dec.reg_wr = 1'b1;
                dec.flow   = FL_JAL;
            end
            OPC_JALR: begin
                dec.use_imm = 1'b1;
                dec.reg_wr  = 1'b1;
                dec.flow    = FL_JALR;
            end
            OPC_STOP: dec.flow = FL_STOP;
            default: ;
        endcase
    end
endmodule

// File: rtl/rv2_alu.sv
module rv2_alu
    import rv2_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_MUL: y = a * b;
            ALU_SLL: y = a << b[4:0];
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/rv2_regfile.sv
module rv2_regfile
    import rv2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/rv2_core.sv
module rv2_core
    import rv2_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int DA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [31:0]     imem_data,
    output logic [DA_W-1:0] dmem_addr,
    output logic            dmem_we,
    output logic [31:0]     dmem_wdata,
    input  logic [31:0]     dmem_rdata,
    output logic            halted
);
    localparam logic [PC_W-1:0] PC_START = PC_W'(1);

    logic [PC_W-1:0] pc, pc_next, pc_inc;
    logic            halt_q;
    dec_t            dec;
    mw_t             mw_q, mw_d;
    logic [XLEN-1:0] rf_a, rf_b, op_a, op_b, alu_b, alu_y, wb_data, link;
    logic            take;

    // first stage: fetch, decode, operands, execute, next location
    rv2_decode u_dec (.instr(imem_data), .dec(dec));

    rv2_regfile u_rf (
        .clk(clk), .rst(rst),
        .we(mw_q.reg_wr), .waddr(mw_q.rd), .wdata(wb_data),
        .raddr_a(dec.rs1), .raddr_b(dec.rs2),
        .rdata_a(rf_a), .rdata_b(rf_b)
    );

    // second-stage result goes straight to the reads behind it
    assign wb_data = mw_q.mem_rd ? dmem_rdata : mw_q.result;

    always_comb begin
        if (dec.rs1 == '0)                            op_a = '0;
        else if (mw_q.reg_wr && mw_q.rd == dec.rs1)   op_a = wb_data;
        else                                          op_a = rf_a;
        if (dec.rs2 == '0)                            op_b = '0;
        else if (mw_q.reg_wr && mw_q.rd == dec.rs2)   op_b = wb_data;
        else                                          op_b = rf_b;
    end

    assign alu_b = dec.use_imm ? dec.imm : op_b;

    rv2_alu u_alu (.op(dec.alu_op), .a(op_a), .b(alu_b), .y(alu_y));

    assign pc_inc = pc + PC_W'(1);
    assign link   = XLEN'({pc_inc, 2'b00});

    always_comb begin
        take = 1'b0;
        unique case (dec.flow)
            FL_BEQ:  take = (op_a == op_b);
            FL_BNE:  take = (op_a != op_b);
            default: ;
        endcase
    end

    always_comb begin
        if (halt_q || dec.flow == FL_STOP)   pc_next = pc;
        else if (dec.flow == FL_JALR)        pc_next = alu_y[PC_W+1:2];
        else if (take || dec.flow == FL_JAL) pc_next = pc + dec.imm[PC_W+1:2];
        else                                 pc_next = pc_inc;
    end

    always_comb begin
        mw_d        = '0;
        mw_d.reg_wr = dec.reg_wr && (dec.rd != '0);
        mw_d.mem_rd = dec.mem_rd;
        mw_d.mem_wr = dec.mem_wr;
        mw_d.rd     = dec.rd;
        mw_d.result = (dec.flow == FL_JAL || dec.flow == FL_JALR) ? link : alu_y;
        mw_d.sdata  = op_b;
        if (halt_q || dec.flow == FL_STOP) mw_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= PC_START;
            halt_q <= 1'b0;
            mw_q   <= '0;
        end else begin
            pc     <= pc_next;
            halt_q <= halt_q || (dec.flow == FL_STOP);
            mw_q   <= mw_d;
        end
    end

    // second stage: memory access and writeback
    assign dmem_addr  = mw_q.result[DA_W+1:2];
    assign dmem_we    = mw_q.mem_wr;
    assign dmem_wdata = mw_q.sdata;
    assign imem_addr  = pc;
    assign halted     = halt_q;
endmodule

// File: rtl/rv2_core_chk.sv
module rv2_core_chk #(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic [31:0]     imem_data,
    input logic            dmem_we,
    input logic            halted
);
    a_r1_reset_start: assert property (@(posedge clk)
        rst |=> (imem_addr == PC_W'(1)));

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!halted && !dmem_we));

    a_r9_halt_on_opcode: assert property (@(posedge clk) disable iff (rst)
        (!halted && imem_data[6:0] == 7'b1111111) |=> halted);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr));

    a_r9_no_store: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);
endmodule

bind rv2_core rv2_core_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_we(dmem_we), .halted(halted)
);

// File: tb/test_rv2_core.sv
`timescale 1ns/1ps
module test_rv2_core;
    localparam int PC_W = 10;
    localparam int DA_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [31:0]     imem_data;
    logic [DA_W-1:0] dmem_addr;
    logic            dmem_we;
    logic [31:0]     dmem_wdata, dmem_rdata;
    logic            halted;

    logic [31:0] imem [1 << PC_W];
    logic [31:0] dmem [1 << DA_W];

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rv2_core #(.PC_W(PC_W), .DA_W(DA_W)) i_rv2_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .halted(halted)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    // expected contents of data words 0..15 after the program halts
    localparam logic [31:0] EXP [16] = '{
        32'd10, 32'd7, 32'd2, 32'd15, 32'd150, 32'd112, 32'd151, 32'd1,
        32'd116, 32'd136, 32'd0, 32'hFFFF_FFFC, 32'd0, 32'd3, 32'd10,
        32'hA5A5_000F
    };
    localparam string EXP_REQ [16] = '{
        "R2", "R2 R4", "R2", "R2", "R2", "R3", "R4 R5", "R6",
        "R7", "R7", "R8", "R2", "R6 R7", "R6", "R4", "R9"
    };

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2,
            input int rs1, input logic [2:0] f3, input int rd);
        return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_i(input int imm, input int rs1,
            input logic [2:0] f3, input int rd, input logic [6:0] op);
        logic [31:0] v = 32'(imm);
        return {v[11:0], 5'(rs1), f3, 5'(rd), op};
    endfunction
    function automatic logic [31:0] enc_s(input int imm, input int rs2, input int rs1);
        logic [31:0] v = 32'(imm);
        return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input int imm, input int rs2, input int rs1,
            input logic [2:0] f3);
        logic [31:0] v = 32'(imm);
        return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input int imm, input int rd);
        logic [31:0] v = 32'(imm);
        return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
    endfunction
    function automatic logic [31:0] addi(input int rd, input int rs1, input int imm);
        return enc_i(imm, rs1, 3'b000, rd, 7'b0010011);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < (1 << PC_W); i++) imem[i] = 32'h0;
        for (int i = 0; i < (1 << DA_W); i++) dmem[i] = 32'hA5A5_0000 + 32'(i);
        imem[1]  = addi(5, 0, 7);
        imem[2]  = addi(6, 0, 3);
        imem[3]  = enc_r(7'b0000000, 6, 5, 3'b000, 7);   // add
        imem[4]  = enc_r(7'b0100000, 6, 7, 3'b000, 8);   // sub
        imem[5]  = enc_r(7'b0000000, 5, 7, 3'b111, 9);   // and
        imem[6]  = enc_r(7'b0000000, 5, 7, 3'b110, 10);  // or
        imem[7]  = enc_r(7'b0000001, 10, 7, 3'b000, 11); // mul
        imem[8]  = enc_i(36, 5, 3'b001, 12, 7'b0010011); // slli, shamt 4
        imem[9]  = enc_s(0, 7, 0);
        imem[10] = enc_s(4, 8, 0);
        imem[11] = enc_s(8, 9, 0);
        imem[12] = enc_s(12, 10, 0);
        imem[13] = enc_s(16, 11, 0);
        imem[14] = enc_s(20, 12, 0);
        imem[15] = enc_i(16, 0, 3'b010, 13, 7'b0000011); // lw
        imem[16] = addi(14, 13, 1);
        imem[17] = enc_s(25, 14, 0);                     // rounds to word 6
        imem[18] = enc_b(8, 8, 5, 3'b000);               // beq taken
        imem[19] = addi(15, 0, 99);
        imem[20] = enc_b(8, 6, 5, 3'b001);               // bne taken
        imem[21] = addi(15, 0, 55);
        imem[22] = enc_b(8, 6, 5, 3'b000);               // beq not taken
        imem[23] = addi(15, 15, 1);
        imem[24] = enc_s(28, 15, 0);
        imem[25] = addi(21, 21, 1);
        imem[26] = enc_b(-4, 6, 21, 3'b001);             // backward loop
        imem[27] = enc_s(52, 21, 0);
        imem[28] = enc_j(12, 1);                         // jal
        imem[29] = addi(16, 0, 77);
        imem[30] = addi(16, 0, 88);
        imem[31] = enc_s(32, 1, 0);
        imem[32] = addi(17, 0, 144);
        imem[33] = enc_i(4, 17, 3'b000, 18, 7'b1100111); // jalr
        imem[34] = addi(16, 0, 66);
        imem[35] = addi(16, 0, 66);
        imem[36] = addi(16, 0, 66);
        imem[37] = enc_s(36, 18, 0);
        imem[38] = addi(0, 0, 5);
        imem[39] = enc_s(40, 0, 0);
        imem[40] = enc_r(7'b0100000, 5, 6, 3'b000, 19);
        imem[41] = enc_s(44, 19, 0);
        imem[42] = enc_s(48, 16, 0);
        imem[43] = enc_i(0, 0, 3'b010, 22, 7'b0000011);
        imem[44] = enc_s(56, 22, 0);
        imem[45] = 32'h0000_007F;                        // halt
        imem[46] = enc_s(60, 5, 0);

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 imem_addr", 32'(imem_addr), 32'd1);
        check("R1 halted", 32'(halted), 32'd0);
        check("R1 dmem_we", 32'(dmem_we), 32'd0);
        rst = 1'b0;

        // R10: 42 executed instructions including the halt
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted || n >= 2000) break;
        end
        if (n >= 2000) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=%0d expected=42", n);
        end else begin
            check("R10 cycles to halt", 32'(n), 32'd42);
        end

        repeat (5) @(negedge clk);
        check("R9 halted held", 32'(halted), 32'd1);
        check("R9 pc frozen", 32'(imem_addr), 32'd45);
        check("R9 no store", 32'(dmem_we), 32'd0);

        for (int k = 0; k < 16; k++)
            check($sformatf("%s word %0d", EXP_REQ[k], k), dmem[k], EXP[k]);

        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset imem_addr", 32'(imem_addr), 32'd1);
        check("R1 re-reset halted", 32'(halted), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule